// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer / Event Counter

This peripheral is an up-counter with a data register, a control register and one external input pin. Software picks one of three counting sources in the control register. Event mode counts edges on the pin. Timer mode counts ticks from an internal power-of-two clock divider. Pulse-width mode is armed by an edge, runs once, and disarms itself. When the counter passes its all-ones value, it reloads from a separate preload register and raises a sticky interrupt request. It also toggles a square-wave output, so the block can act as a programmable frequency divider: the output frequency is the count rate divided by 2 × (2^CNT_W − N).

Writes to the data register behave differently depending on the run bit. While the timer is stopped, a write sets both the counter and the preload. While the timer is running, a write changes only the preload, and the new value takes effect at the next wrap. Reading the counter freezes counting for that cycle and captures the value into a read-back port.

Top module: `evt_timer8`

## Requirements
- R1: Control-register layout: bits 2..0 select the divider, bit 3 selects the edge, bit 4 is the run bit and bits 7..6 select the mode. Bit 5 always reads back as 0, whatever value was written to it.
- R2: Mode code 00 never advances the counter, even with the run bit set.
- R3: In timer mode (code 10) the counter advances once per divider tick. Divider code k gives one tick every 2^(k+1) system clocks, and the divider is free-running from reset.
- R4: When an advance would leave the all-ones value, the counter instead loads the preload value and the sticky request flag sets in that same cycle. Pulsing the flag-clear input clears the flag, but a wrap in the same cycle keeps it set.
- R5: A data write while the run bit is 0 loads both the counter and the preload register.
- R6: A data write while the run bit is 1 changes only the preload register. The counter keeps counting and picks up the new value at its next wrap.
- R7: Pulse-width mode (code 11) with the run bit set arms on the selected pin edge. It counts divider ticks from the next cycle, and it stops on the opposite edge, where the run bit clears itself.
- R8: After a pulse-width measurement completes, further pin edges leave the count unchanged until software sets the run bit again.
- R9: Edge select 0 makes rising pin edges active, and edge select 1 makes falling pin edges active.
- R10: The square-wave output starts low and inverts once for every wrap.
- R11: The interrupt output equals the sticky flag ANDed with the interrupt-enable input.
- R12: A read pulse blocks counting in that cycle, and the read-back port shows the counter value from before that edge starting in the next cycle.
- R13: In event mode (code 01) the counter advances once per active pin edge. The pin passes through a two-stage synchroniser plus an edge register, so a pin change is counted at the third clock edge after it, and the divider has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr_i | input | 1 | Write strobe for the data (count/preload) register |
| ctrl_wr_i | input | 1 | Write strobe for the control register |
| wdata_i | input | CNT_W | Write data; the control register takes the low 8 bits |
| data_rd_i | input | 1 | Read strobe for the counter |
| ext_pin_i | input | 1 | External event / pulse input (asynchronous) |
| irq_en_i | input | 1 | Interrupt enable gate |
| flag_clr_i | input | 1 | Clears the sticky request flag |
| ctrl_o | output | 8 | Control register read-back |
| cnt_rd_o | output | CNT_W | Counter value captured by the last read |
| irq_flag_o | output | 1 | Sticky wrap request flag |
| irq_o | output | 1 | Gated interrupt request |
| pfd_o | output | 1 | Square wave toggled on each wrap |

## Verification
The assertions assume that every strobe input changes only between clock edges. They also assume that software does not rewrite the control register in the same cycle as a pulse-width stop edge; when that happens the write wins, and the property about the run bit clearing itself is qualified so that it does not fire. The bench drives all inputs half a clock away from the sampling edge. It holds the external pin steady for several cycles between changes, so every edge passes through the synchroniser cleanly. Each run-bit change is made by a whole-register control write, never by a partial update.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   localparam int PSC_W = 3;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_EVT = 2'b01,
      MODE_TMR = 2'b10,
      MODE_PW  = 2'b11
   } tmr_mode_e;

   typedef struct packed {
      tmr_mode_e        mode;
      logic             rsvd;
      logic             run;
      logic             edge_fall;
      logic [PSC_W-1:0] psc;
   } tmr_ctrl_t;
endpackage

// File: rtl/evt_timer8_sync.sv
module evt_timer8_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evt_timer8_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;

   AST_EDGE_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);  // R13
endmodule

// File: rtl/evt_timer8_presc.sv
module evt_timer8_presc #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int DIV_W = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("evt_timer8_presc: SEL_W out of range");
   end

   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
   end

   assign mask   = ~({DIV_W{1'b1}} << ({1'b0, sel_i} + 1'b1));
   assign tick_o = ((pcnt_q & mask) == mask);

   AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && $stable(sel_i)) |=> !tick_o);  // R3
endmodule

// File: rtl/evt_timer8_pwctl.sv
module evt_timer8_pwctl (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic act_i,
   input  logic inact_i,
   output logic meas_o,
   output logic done_o
);
   logic meas_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 meas_q <= 1'b0;
      else if (!arm_i)            meas_q <= 1'b0;
      else if (!meas_q && act_i)  meas_q <= 1'b1;
      else if (meas_q && inact_i) meas_q <= 1'b0;
   end

   assign meas_o = meas_q;
   assign done_o = arm_i & meas_q & inact_i;

   AST_PW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !meas_o);  // R8
   AST_PW_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && !meas_o && act_i) |=> meas_o);  // R7
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
   import tmr8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr_i,
   input  logic             ctrl_wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             data_rd_i,
   input  logic             ext_pin_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   output logic [7:0]       ctrl_o,
   output logic [CNT_W-1:0] cnt_rd_o,
   output logic             irq_flag_o,
   output logic             irq_o,
   output logic             pfd_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_width
      $error("evt_timer8: CNT_W must be within 8..32");
   end

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] cnt_q, pre_q, rd_q;
   logic             flag_q, pfd_q;
   logic             rise, fall, act, inact, tick;
   logic             pw_arm, pw_meas, pw_done;
   logic             run, cen, ovf, idle_wr;

   evt_timer8_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i),
      .rise_o(rise), .fall_o(fall)
   );

   evt_timer8_presc #(.SEL_W(PSC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .sel_i(ctrl_q.psc), .tick_o(tick)
   );

   assign run    = ctrl_q.run;
   assign act    = ctrl_q.edge_fall ? fall : rise;
   assign inact  = ctrl_q.edge_fall ? rise : fall;
   assign pw_arm = run && (ctrl_q.mode == MODE_PW);

   evt_timer8_pwctl u_pw (
      .clk(clk), .rst_n(rst_n), .arm_i(pw_arm), .act_i(act),
      .inact_i(inact), .meas_o(pw_meas), .done_o(pw_done)
   );

   always_comb begin
      cen = 1'b0;
      if (!data_rd_i) begin
         unique case (ctrl_q.mode)
            MODE_EVT: cen = run && act;
            MODE_TMR: cen = run && tick;
            MODE_PW:  cen = pw_arm && pw_meas && tick;
            default:  cen = 1'b0;
         endcase
      end
   end

   assign ovf     = cen && (cnt_q == CNT_TOP);
   assign idle_wr = data_wr_i && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (idle_wr) cnt_q <= wdata_i;
      else if (ovf)     cnt_q <= pre_q;
      else if (cen)     cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q <= '0;
      else if (data_wr_i) pre_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr_i) begin
         ctrl_q      <= tmr_ctrl_t'(wdata_i[7:0]);
         ctrl_q.rsvd <= 1'b0;
      end else if (pw_done) begin
         ctrl_q.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pfd_q  <= 1'b0;
         rd_q   <= '0;
      end else begin
         if (ovf)             flag_q <= 1'b1;
         else if (flag_clr_i) flag_q <= 1'b0;
         if (ovf)             pfd_q  <= ~pfd_q;
         if (data_rd_i)       rd_q   <= cnt_q;
      end
   end

   assign ctrl_o     = ctrl_q;
   assign cnt_rd_o   = rd_q;
   assign irq_flag_o = flag_q;
   assign irq_o      = flag_q & irq_en_i;
   assign pfd_o      = pfd_q;

   AST_MODE_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mode == MODE_OFF && !data_wr_i) |=> $stable(cnt_q));  // R2
   AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> irq_flag_o);  // R4
   AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !idle_wr) |=> (cnt_q == $past(pre_q)));  // R4
   AST_IDLE_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_wr |=> (cnt_q == $past(wdata_i) && pre_q == $past(wdata_i)));  // R5
   AST_BUSY_WRITE_PRELOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && run && !cen) |=> $stable(cnt_q));  // R6
   AST_PW_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_done && !ctrl_wr_i) |=> !ctrl_o[4]);  // R7
   AST_PFD_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (pfd_o != $past(pfd_o)));  // R10
   AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && !idle_wr) |=> (cnt_q == $past(cnt_q) && cnt_rd_o == $past(cnt_q)));  // R12
endmodule

// File: tb/tb_evt_timer8.sv
`timescale 1ns/100ps
module tb_evt_timer8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_wr_i = 0, ctrl_wr_i = 0, data_rd_i = 0;
   logic [7:0] wdata_i = 0;
   logic       ext_pin_i = 0, irq_en_i = 0, flag_clr_i = 0;
   logic [7:0] ctrl_o, cnt_rd_o;
   logic       irq_flag_o, irq_o, pfd_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [7:0] held;

   always #2.5 clk = ~clk;

   evt_timer8 dut (
      .clk(clk), .rst_n(rst_n), .data_wr_i(data_wr_i), .ctrl_wr_i(ctrl_wr_i),
      .wdata_i(wdata_i), .data_rd_i(data_rd_i), .ext_pin_i(ext_pin_i),
      .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .ctrl_o(ctrl_o),
      .cnt_rd_o(cnt_rd_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o), .pfd_o(pfd_o)
   );

   // behavioural reference
   logic [7:0] m_cnt, m_pre, m_ctrl, m_rd, m_pc;
   logic       m_flag, m_pfd, m_meas, m_s1, m_s2, m_prev;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_ctrl = 0; m_rd = 0; m_pc = 0;
         m_flag = 0; m_pfd = 0; m_meas = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      end else begin
         automatic bit rise_e  = m_s2 && !m_prev;
         automatic bit fall_e  = !m_s2 && m_prev;
         automatic bit act_e   = m_ctrl[3] ? fall_e : rise_e;
         automatic bit inact_e = m_ctrl[3] ? rise_e : fall_e;
         automatic int period  = 2 << m_ctrl[2:0];
         automatic bit tk      = (int'(m_pc) % period) == period - 1;
         automatic bit run     = m_ctrl[4];
         automatic int mode    = m_ctrl[7:6];
         automatic bit adv     = 0;
         automatic bit wrap;
         automatic logic [7:0] n_cnt = m_cnt;
         automatic logic [7:0] n_ctrl = m_ctrl;
         automatic bit n_meas;
         if (!data_rd_i) begin
            if (mode == 1) adv = run && act_e;
            if (mode == 2) adv = run && tk;
            if (mode == 3) adv = run && m_meas && tk;
         end
         wrap = adv && (m_cnt == 8'hFF);
         if (adv) n_cnt = wrap ? m_pre : m_cnt + 8'd1;
         if (data_wr_i && !run) n_cnt = wdata_i;
         if (!(run && mode == 3)) n_meas = 0;
         else if (!m_meas && act_e) n_meas = 1;
         else if (m_meas && inact_e) n_meas = 0;
         else n_meas = m_meas;
         if (run && mode == 3 && m_meas && inact_e) n_ctrl[4] = 0;
         if (ctrl_wr_i) n_ctrl = wdata_i & 8'hDF;
         if (wrap) m_flag = 1; else if (flag_clr_i) m_flag = 0;
         if (wrap) m_pfd = !m_pfd;
         if (data_rd_i) m_rd = m_cnt;
         if (data_wr_i) m_pre = wdata_i;
         m_cnt = n_cnt; m_ctrl = n_ctrl; m_meas = n_meas;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin_i;
         m_pc = m_pc + 8'd1;
      end
   end

   task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      #1;
      cycles++;
      if (rst_n) begin
         chk("R1 ctrl readback", ctrl_o, m_ctrl);
         chk("R12 read port", cnt_rd_o, m_rd);
         chk("R4 flag", {7'd0, irq_flag_o}, {7'd0, m_flag});
         chk("R11 irq gate", {7'd0, irq_o}, {7'd0, m_flag & irq_en_i});
         chk("R10 square wave", {7'd0, pfd_o}, {7'd0, m_pfd});
      end
      if (cycles > 200000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr_ctrl(logic [7:0] v);
      @(negedge clk); ctrl_wr_i = 1; wdata_i = v;
      @(negedge clk); ctrl_wr_i = 0;
   endtask
   task automatic wr_data(logic [7:0] v);
      @(negedge clk); data_wr_i = 1; wdata_i = v;
      @(negedge clk); data_wr_i = 0;
   endtask
   task automatic rd_cnt();
      @(negedge clk); data_rd_i = 1;
      @(negedge clk); data_rd_i = 0; #1;
   endtask
   task automatic pulse(logic lvl, int width, int gap);
      @(negedge clk); ext_pin_i = lvl; step(width);
      ext_pin_i = !lvl; step(gap);
   endtask

   initial begin
      step(3);
      chk("R1 reset ctrl", ctrl_o, 8'h00);
      chk("R4 reset flag", {7'd0, irq_flag_o}, 8'h00);
      chk("R10 reset pfd", {7'd0, pfd_o}, 8'h00);
      rst_n = 1;
      step(2);

      wr_ctrl(8'hEF); #1;
      chk("R1 bit5 reads zero", ctrl_o, 8'hCF);
      wr_ctrl(8'h00);
      wr_data(8'h3C);
      rd_cnt();
      chk("R5 idle write loads counter", cnt_rd_o, 8'h3C);

      wr_ctrl(8'h10); step(20);
      rd_cnt();
      chk("R2 mode 00 holds", cnt_rd_o, 8'h3C);

      wr_ctrl(8'h00); wr_data(8'h00);
      wr_ctrl(8'h93); step(70);
      rd_cnt();
      chk("R3 divide-by-16 count", cnt_rd_o, m_rd);

      wr_ctrl(8'h00); wr_data(8'hF8);
      wr_ctrl(8'h90); step(4);
      wr_data(8'h80);
      rd_cnt();
      chk("R6 busy write keeps count", cnt_rd_o, m_rd);
      step(20);
      rd_cnt();
      chk("R6 wrap used new preload", cnt_rd_o, m_rd);
      chk("R4 flag after wrap", {7'd0, irq_flag_o}, 8'h01);
      repeat (5) begin
         rd_cnt();
         chk("R12 read during run", cnt_rd_o, m_rd);
      end

      wr_ctrl(8'h00);
      irq_en_i = 0; step(1); #1;
      chk("R11 gated off", {7'd0, irq_o}, 8'h00);
      irq_en_i = 1; step(1); #1;
      chk("R11 gated on", {7'd0, irq_o}, 8'h01);
      @(negedge clk); flag_clr_i = 1; @(negedge clk); flag_clr_i = 0; #1;
      chk("R4 flag cleared", {7'd0, irq_flag_o}, 8'h00);

      wr_ctrl(8'h47); wr_data(8'hFD);
      wr_ctrl(8'h57);
      repeat (4) pulse(1'b1, 4, 4);
      rd_cnt();
      chk("R13 event count with wrap", cnt_rd_o, m_rd);
      chk("R13 event wrap flag", {7'd0, irq_flag_o}, 8'h01);

      wr_ctrl(8'h48); wr_data(8'h10);
      wr_ctrl(8'h58);
      repeat (3) pulse(1'b1, 5, 3);
      rd_cnt();
      chk("R9 falling-edge count", cnt_rd_o, 8'h13);

      wr_ctrl(8'hC0); wr_data(8'h00);
      wr_ctrl(8'hD0); step(6);
      pulse(1'b1, 30, 10); #1;
      chk("R7 run bit self-clears", {7'd0, ctrl_o[4]}, 8'h00);
      rd_cnt();
      chk("R7 pulse width counted", cnt_rd_o, m_rd);
      held = cnt_rd_o;
      pulse(1'b1, 20, 10);
      rd_cnt();
      chk("R8 later pulse ignored", cnt_rd_o, held);

      @(negedge clk); ext_pin_i = 1; step(6);
      wr_ctrl(8'hC9); wr_data(8'hF0);
      wr_ctrl(8'hD9); step(4);
      pulse(1'b0, 40, 10);
      rd_cnt();
      chk("R9 low pulse measured", cnt_rd_o, m_rd);
      chk("R7 low pulse run cleared", {7'd0, ctrl_o[4]}, 8'h00);

      wr_ctrl(8'h00); wr_data(8'hFC);
      wr_ctrl(8'h90); step(60);
      chk("R10 square wave after wraps", {7'd0, pfd_o}, {7'd0, m_pfd});

      step(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule